// File: doc/BRIEF.md
# Pulse-Width Voltage-Code Decoder

This block turns a pulse-width-modulated voltage-identification input into a numeric reference step. A fast sampling clock runs a fixed measurement window of `STEPS_MAX * UNIT_CLKS` clocks, where one quantum (a unit pulse) is `UNIT_CLKS` clocks long. The number of clocks during which the input is high is counted over each window. At the end of the window the count is rounded to the nearest whole quantum and published as a step code between 0 and `STEPS_MAX`. A wholly low input gives 0 and a wholly high input gives `STEPS_MAX`.

The analog front end cannot be seen by synthesizable logic, so it reports two facts as plain inputs: whether the input pin is currently undriven, and whether the external standby switch is enabled. From these two inputs the block derives one of three operating modes: boot, normal or standby. In boot mode the target reference is a fixed boot step. In standby mode it is a fixed, very low standby step. In normal mode it is the decoded step code.

A separate reference code moves toward the target at a limited rate. It moves by one step on each tick of a divider whose interval is programmable, and the rule is the same for rising and falling moves. Downstream logic uses this reference code as the setpoint that moves smoothly.

Top module: `pwm_vid_decoder`

## Requirements
- R1: While reset is asserted, `stepCode` and `refCode` are 0 and `modeCode` is 0 (boot).
- R2: Measurement windows are `STEPS_MAX*UNIT_CLKS` clocks long and start at the first clock after reset is released. `stepCode` changes only on the last clock edge of a window and holds its value through the window.
- R3: At the end of a clean window with `h` high samples, `stepCode` equals `min(floor((h + UNIT_CLKS/2) / UNIT_CLKS), STEPS_MAX)`, so the count rounds half up to the nearest quantum.
- R4: One clock after the inputs are sampled, `modeCode` shows 0 (boot) when the input is undriven and standby is disabled, 2 (standby) when the input is undriven and standby is enabled, and 1 (normal) when the input is driven, whatever `standbyEn` is.
- R5: A window in which `vidUndriven` is high on any sample leaves `stepCode` unchanged. The next clean window decodes normally.
- R6: The target for `refCode` is `BOOT_CODE` in boot mode, `STANDBY_CODE` in standby mode and `stepCode` in normal mode.
- R7: `refCode` changes by exactly one step toward the target on each slew tick and does not change between ticks. While it is moving, successive changes are `slewDiv+1` clocks apart, for both rising and falling moves.
- R8: Once `refCode` equals the target it stays there. The number of steps taken equals the distance from the starting value to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidIn | input | 1 | Pulse-width-modulated voltage-code input |
| vidUndriven | input | 1 | High while the input pin is sensed as undriven |
| standbyEn | input | 1 | External standby switch enable |
| slewDiv | input | SLEW_W | Reference moves one step every slewDiv+1 clocks |
| stepCode | output | $clog2(STEPS_MAX+1) | Decoded step of the last clean window |
| modeCode | output | 2 | 0 boot, 1 normal, 2 standby |
| refCode | output | $clog2(STEPS_MAX+1) | Slew-limited reference step |

## Verification
The assertions check four things on every cycle: the decoded step never exceeds `STEPS_MAX` and changes only on a window-end strobe, the mode follows the two sense inputs one clock later, and the reference moves by at most one step, only on a slew tick and never away from a target it has already reached. What the bench scenarios can show and the assertions cannot is the arithmetic of the decode: the rounding point across every possible high count, the discarding of a window that contained an undriven sample, and the spacing of reference steps measured in clocks for both directions and more than one divider setting.

// File: rtl/pwm_vid_pkg.sv
package pwm_vid_pkg;

  typedef enum logic [1:0] {
    MODE_BOOT    = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_STANDBY = 2'd2
  } vidMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic periodStart;
    logic periodEnd;
    logic slewTick;
  } vidStrobe_t;

endpackage

// File: rtl/pwm_vid_ctrl.sv
module pwm_vid_ctrl
  import pwm_vid_pkg::*;
#(
  parameter int PERIOD_CLKS = 256,
  parameter int SLEW_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLEW_W-1:0] slewDiv,
  output vidStrobe_t        strobes
);

  localparam int PC_W = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
  localparam logic [PC_W-1:0] PHASE_LAST = PC_W'(PERIOD_CLKS - 1);

  logic [PC_W-1:0]   phaseCnt;
  logic [SLEW_W-1:0] slewCnt;
  logic              slewHit;

  // Free-running measurement window phase
  always_ff @(posedge clk) begin
    if (!rstN)                      phaseCnt <= '0;
    else if (phaseCnt == PHASE_LAST) phaseCnt <= '0;
    else                            phaseCnt <= phaseCnt + 1'b1;
  end

  assign slewHit = (slewCnt >= slewDiv);

  // Slew divider: one tick every slewDiv+1 clocks
  always_ff @(posedge clk) begin
    if (!rstN)        slewCnt <= '0;
    else if (slewHit) slewCnt <= '0;
    else              slewCnt <= slewCnt + 1'b1;
  end

  always_comb begin
    strobes.periodStart = (phaseCnt == '0);
    strobes.periodEnd   = (phaseCnt == PHASE_LAST);
    strobes.slewTick    = slewHit;
  end

endmodule

// File: rtl/pwm_vid_dp.sv
module pwm_vid_dp
  import pwm_vid_pkg::*;
#(
  parameter int STEPS_MAX     = 64,
  parameter int UNIT_CLKS     = 4,
  parameter int BOOT_CODE     = 24,
  parameter int STANDBY_CODE  = 2,
  parameter int ROUND_NEAREST = 1,
  parameter int STEP_W        = $clog2(STEPS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vidIn,
  input  logic              vidUndriven,
  input  logic              standbyEn,
  input  vidStrobe_t        strobes,
  output logic [STEP_W-1:0] stepCode,
  output logic [1:0]        modeCode,
  output logic [STEP_W-1:0] refCode,
  output logic [STEP_W-1:0] targetCode
);

  localparam int PERIOD_CLKS = STEPS_MAX * UNIT_CLKS;
  localparam int HC_W        = $clog2(PERIOD_CLKS + 1);
  localparam int QW          = HC_W + 1;

  logic [HC_W-1:0]   highCnt, highNext;
  logic              cleanQ, cleanNext;
  logic [QW-1:0]     biasedCnt, quotient;
  logic [STEP_W-1:0] decoded;
  logic [STEP_W-1:0] stepQ, refQ, targetNow;
  vidMode_e          modeQ, modeNext;

  // High-time accumulation; window restarts on periodStart
  always_comb begin
    highNext  = (strobes.periodStart ? '0 : highCnt)
              + HC_W'(vidIn & ~vidUndriven);
    cleanNext = (strobes.periodStart ? 1'b1 : cleanQ) & ~vidUndriven;
  end

  // Rounding variant chosen by parameter
  generate
    if (ROUND_NEAREST != 0) begin : g_round
      assign biasedCnt = {1'b0, highNext} + QW'(UNIT_CLKS / 2);
    end else begin : g_trunc
      assign biasedCnt = {1'b0, highNext};
    end
  endgenerate

  assign quotient = biasedCnt / QW'(UNIT_CLKS);
  assign decoded  = (quotient > QW'(STEPS_MAX)) ? STEP_W'(STEPS_MAX)
                                                : quotient[STEP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= '0;
      cleanQ  <= 1'b1;
      stepQ   <= '0;
    end else begin
      highCnt <= highNext;
      cleanQ  <= cleanNext;
      if (strobes.periodEnd && cleanNext) stepQ <= decoded;
    end
  end

  // Mode decision from the sense inputs
  always_comb begin
    if (vidUndriven) modeNext = standbyEn ? MODE_STANDBY : MODE_BOOT;
    else             modeNext = MODE_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_BOOT;
    else       modeQ <= modeNext;
  end

  always_comb begin
    case (modeQ)
      MODE_BOOT:    targetNow = STEP_W'(BOOT_CODE);
      MODE_STANDBY: targetNow = STEP_W'(STANDBY_CODE);
      default:      targetNow = stepQ;
    endcase
  end

  // Slew-limited reference, symmetric up and down
  always_ff @(posedge clk) begin
    if (!rstN) refQ <= '0;
    else if (strobes.slewTick) begin
      if (refQ < targetNow)      refQ <= refQ + 1'b1;
      else if (refQ > targetNow) refQ <= refQ - 1'b1;
    end
  end

  assign stepCode   = stepQ;
  assign modeCode   = modeQ;
  assign refCode    = refQ;
  assign targetCode = targetNow;

endmodule

// File: rtl/pwm_vid_decoder.sv
module pwm_vid_decoder
  import pwm_vid_pkg::*;
#(
  parameter int STEPS_MAX     = 64,
  parameter int UNIT_CLKS     = 4,
  parameter int SLEW_W        = 8,
  parameter int BOOT_CODE     = 24,
  parameter int STANDBY_CODE  = 2,
  parameter int ROUND_NEAREST = 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             vidIn,
  input  logic                             vidUndriven,
  input  logic                             standbyEn,
  input  logic [SLEW_W-1:0]                slewDiv,
  output logic [$clog2(STEPS_MAX+1)-1:0]   stepCode,
  output logic [1:0]                       modeCode,
  output logic [$clog2(STEPS_MAX+1)-1:0]   refCode
);

  localparam int STEP_W      = $clog2(STEPS_MAX + 1);
  localparam int PERIOD_CLKS = STEPS_MAX * UNIT_CLKS;

  vidStrobe_t        strobes;
  logic [STEP_W-1:0] targetCode;

  pwm_vid_ctrl #(
    .PERIOD_CLKS (PERIOD_CLKS),
    .SLEW_W      (SLEW_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .slewDiv (slewDiv),
    .strobes (strobes)
  );

  pwm_vid_dp #(
    .STEPS_MAX     (STEPS_MAX),
    .UNIT_CLKS     (UNIT_CLKS),
    .BOOT_CODE     (BOOT_CODE),
    .STANDBY_CODE  (STANDBY_CODE),
    .ROUND_NEAREST (ROUND_NEAREST),
    .STEP_W        (STEP_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .vidIn       (vidIn),
    .vidUndriven (vidUndriven),
    .standbyEn   (standbyEn),
    .strobes     (strobes),
    .stepCode    (stepCode),
    .modeCode    (modeCode),
    .refCode     (refCode),
    .targetCode  (targetCode)
  );

endmodule

// File: rtl/pwm_vid_decoder_chk.sv
module pwm_vid_decoder_chk
  import pwm_vid_pkg::*;
#(
  parameter int STEPS_MAX = 64,
  parameter int STEP_W    = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              vidUndriven,
  input logic              standbyEn,
  input logic [STEP_W-1:0] stepCode,
  input logic [1:0]        modeCode,
  input logic [STEP_W-1:0] refCode,
  input logic [STEP_W-1:0] targetCode,
  input vidStrobe_t        strobes
);

  assert_step_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    int'(stepCode) <= STEPS_MAX);

  assert_step_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.periodEnd |=> $stable(stepCode));

  assert_mode_boot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vidUndriven && !standbyEn) |=> modeCode == 2'd0);

  assert_mode_standby_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vidUndriven && standbyEn) |=> modeCode == 2'd2);

  assert_mode_normal_R4: assert property (@(posedge clk) disable iff (!rstN)
    !vidUndriven |=> modeCode == 2'd1);

  assert_ref_unit_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (int'(refCode) - int'($past(refCode)) <= 1) &&
             (int'($past(refCode)) - int'(refCode) <= 1));

  assert_ref_no_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.slewTick |=> $stable(refCode));

  assert_ref_settled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refCode == targetCode) |=> $stable(refCode));

endmodule

bind pwm_vid_decoder pwm_vid_decoder_chk #(
  .STEPS_MAX (STEPS_MAX),
  .STEP_W    (STEP_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .vidUndriven (vidUndriven),
  .standbyEn   (standbyEn),
  .stepCode    (stepCode),
  .modeCode    (modeCode),
  .refCode     (refCode),
  .targetCode  (targetCode),
  .strobes     (strobes)
);

// File: tb/pwm_vid_decoder_tb_top.sv
`timescale 1ns/1ps
module pwm_vid_decoder_tb_top;

  localparam int NMAX  = 8;
  localparam int UCLK  = 4;
  localparam int PER   = NMAX * UCLK;
  localparam int BOOTC = 6;
  localparam int STBYC = 1;

  logic       clk = 1'b0;
  logic       rstN;
  logic       vidIn, vidUndriven, standbyEn;
  logic [7:0] slewDiv;
  logic [3:0] stepCode, refCode;
  logic [1:0] modeCode;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pwm_vid_decoder #(
    .STEPS_MAX     (NMAX),
    .UNIT_CLKS     (UCLK),
    .SLEW_W        (8),
    .BOOT_CODE     (BOOTC),
    .STANDBY_CODE  (STBYC),
    .ROUND_NEAREST (1)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .vidIn       (vidIn),
    .vidUndriven (vidUndriven),
    .standbyEn   (standbyEn),
    .slewDiv     (slewDiv),
    .stepCode    (stepCode),
    .modeCode    (modeCode),
    .refCode     (refCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One full window: high for the first h samples, undriven in [udFrom, udTo)
  task automatic runPeriod(input int h, input int udFrom, input int udTo);
    for (int i = 0; i < PER; i++) begin
      vidIn       = (i < h);
      vidUndriven = (i >= udFrom) && (i < udTo);
      tick();
    end
    vidUndriven = 1'b0;
  endtask

  function automatic int expStep(input int h);
    int q = (h + UCLK / 2) / UCLK;
    return (q > NMAX) ? NMAX : q;
  endfunction

  // Watch refCode move toward tgt; check size, direction, spacing, end value
  task automatic observe(input int tgt, input int cyc, input int d);
    int prev    = int'(refCode);
    int start   = prev;
    int lastChg = -1;
    int moves   = 0;
    for (int c = 0; c < cyc; c++) begin
      tick();
      if (int'(refCode) != prev) begin
        moves++;
        chk("R7 step size and direction", int'(refCode) - prev, (tgt > prev) ? 1 : -1);
        if (lastChg >= 0) chk("R7 step spacing", c - lastChg, d + 1);
        lastChg = c;
        prev    = int'(refCode);
      end
    end
    chk("R6 settled target", int'(refCode), tgt);
    chk("R8 step count", moves, (tgt > start) ? tgt - start : start - tgt);
  endtask

  initial begin
    rstN = 1'b0; vidIn = 1'b0; vidUndriven = 1'b1; standbyEn = 1'b0; slewDiv = 8'd0;
    repeat (3) tick();
    chk("R1 reset stepCode", int'(stepCode), 0);
    chk("R1 reset refCode", int'(refCode), 0);
    chk("R1 reset modeCode", int'(modeCode), 0);
    rstN = 1'b1;
    vidUndriven = 1'b0;

    // R3: every possible high count over a clean window
    for (int h = 0; h <= PER; h++) begin
      runPeriod(h, PER, PER);
      chk($sformatf("R3 decode h=%0d", h), int'(stepCode), expStep(h));
    end
    chk("R4 driven gives normal", int'(modeCode), 1);

    // R2: code holds until the last edge of the window
    for (int i = 0; i < PER; i++) begin
      vidIn = 1'b0;
      tick();
      if (i == PER - 2) chk("R2 hold before window end", int'(stepCode), NMAX);
    end
    chk("R2 update at window end", int'(stepCode), 0);

    // R5: undriven samples void the window
    runPeriod(20, PER, PER);
    chk("R3 decode 20 high", int'(stepCode), 5);
    runPeriod(PER, 10, 13);
    chk("R5 voided window keeps code", int'(stepCode), 5);
    runPeriod(PER, 0, 1);
    chk("R5 voided at first sample", int'(stepCode), 5);
    runPeriod(PER, PER, PER);
    chk("R5 clean window decodes", int'(stepCode), NMAX);

    // R4: mode from sense inputs
    vidUndriven = 1'b1; standbyEn = 1'b0; tick();
    chk("R4 undriven gives boot", int'(modeCode), 0);
    standbyEn = 1'b1; tick();
    chk("R4 undriven with standby", int'(modeCode), 2);
    vidUndriven = 1'b0; tick();
    chk("R4 standbyEn ignored when driven", int'(modeCode), 1);

    // R6/R7/R8: slew in both directions
    standbyEn = 1'b0;
    observe(NMAX, 40, 0);
    slewDiv = 8'd3;
    vidUndriven = 1'b1; standbyEn = 1'b1;
    observe(STBYC, 60, 3);
    chk("R4 standby during slew", int'(modeCode), 2);
    standbyEn = 1'b0;
    slewDiv = 8'd5;
    observe(BOOTC, 60, 5);
    slewDiv = 8'd3;
    vidUndriven = 1'b0;
    observe(NMAX, 40, 3);
    chk("R5 code kept across undriven spell", int'(stepCode), NMAX);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule